// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block collects up to 32 interrupt request lines and drives one active-low interrupt line toward a processor. Each source has a priority and a trigger mode (high level, low level, rising edge or falling edge), and it has a 32-bit vector that software programs. Sources pass a per-source enable mask. The interrupt line is asserted when a pending, enabled source outranks the level that is being serviced.

Software services an interrupt by reading the vector port. That read is the acknowledge. It returns the vector of the winning source, clears that source's edge latch, and pushes the source's priority and number onto an 8-level nesting stack. Only a strictly higher priority can interrupt a handler that is running. An end-of-interrupt write pops one level. If the vector port is read when nothing qualifies, it returns a programmable spurious vector and the stack does not change. Write-one command words enable, disable, set and clear sources as a group.

The bus is a simple single-cycle register port. The write or read is taken at the clock edge where `bus_sel` is high. Read data appears on `bus_rdata` after that edge and holds until the next read. Byte addresses are used, and all registers are word aligned.

Top module: `vnic_top`

## Requirements
- R1: After reset, `irq_n` is high and the stack is empty. The mask, pending, status, spurious, vector and debug registers all read zero. Every mode register reads zero, which means priority 0 and high level.
- R2: The mode register of source n is at byte address 4n. Bits [2:0] hold the priority, where 7 is the highest. Bits [6:5] hold the trigger: 00 high level, 01 rising edge, 10 low level, 11 falling edge. All other bits read zero. The vector of source n is a full 32-bit read/write word at 0x80+4n, and the spurious vector is a read/write word at 0x134.
- R3: The mask reads at 0x110. A write to 0x120 sets the mask bits that are one in the data, and a write to 0x124 clears them. Zero bits leave the mask unchanged.
- R4: The raw pending word reads at 0x10C. A level source is pending while its sampled input is at the active level, starting one edge after the input changes. An edge source latches two edges after the input changes and stays pending until it is cleared or acknowledged.
- R5: A write to 0x12C sets the pending latch of every source whose bit is one, which acts as a software retrigger. A write to 0x128 clears the latches whose bits are one. Zero bits have no effect.
- R6: `irq_n` is low exactly when some pending, enabled source has a priority strictly greater than the priority on top of the stack. An empty stack counts as lower than priority 0.
- R7: A read of 0x100 while `irq_n` is low returns the vector of the highest-priority pending, enabled source, and a tie goes to the lower source number. At the same edge the read clears that source's latch and pushes its priority and number.
- R8: A read of 0x100 while `irq_n` is high returns the spurious vector and leaves the stack unchanged.
- R9: The status word at 0x108 reads the number of the source on top of the stack, or zero when the stack is empty.
- R10: A write to 0x130 pops one stack level. A write to 0x130 with an empty stack has no effect. The stack holds at most 8 levels, and a push beyond that is discarded, so 8 end-of-interrupt writes always empty it.
- R11: The debug control word at 0x138 reads back bit 0 of the last write, and its other bits read zero. The command words and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt request lines, one per source |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held between reads |
| irq_n | output | 1 | Interrupt request to the processor, active low |

## Verification
Each register write takes effect at the edge that accepts it, so a read issued at the next edge sees the new value. Read data is due on `bus_rdata` just after the edge of the read. A level input is pending one edge after it changes, and an edge input is pending two edges after. `irq_n` follows the registered state directly, so it changes right after the edge that moves the mask, a latch or the stack. The bench runs a behavioural model that applies the same edge-by-edge rules. It compares `irq_n` at every falling clock edge, and it compares each read at the falling edge after the read's rising edge. Every comparison therefore falls half a cycle after the edge on which the result becomes due.

// File: rtl/vnic_pkg.sv
package vnic_pkg;

  localparam int PRIO_W        = 3;
  localparam int MODE_TRIG_LSB = 5;

  localparam int A_VEC_BASE = 'h080;
  localparam int A_ACK      = 'h100;
  localparam int A_STATUS   = 'h108;
  localparam int A_PEND     = 'h10C;
  localparam int A_MASK     = 'h110;
  localparam int A_EN       = 'h120;
  localparam int A_DIS      = 'h124;
  localparam int A_CLR      = 'h128;
  localparam int A_SET      = 'h12C;
  localparam int A_EOI      = 'h130;
  localparam int A_SPUR     = 'h134;
  localparam int A_DBG      = 'h138;

  typedef logic [PRIO_W-1:0] prio_t;

  // bit 1: active-low polarity, bit 0: edge sensitive
  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  function automatic logic trig_is_edge(trig_e t);
    return t[0];
  endfunction

  function automatic logic trig_is_low(trig_e t);
    return t[1];
  endfunction

  function automatic logic level_active(trig_e t, logic cur);
    return trig_is_low(t) ? ~cur : cur;
  endfunction

  function automatic logic edge_seen(trig_e t, logic cur, logic prev);
    return trig_is_low(t) ? (prev & ~cur) : (~prev & cur);
  endfunction

  // strict preemption test; an empty stack ranks below every priority
  function automatic logic outranks(prio_t cand, logic stk_valid, prio_t stk_top);
    return !stk_valid || (cand > stk_top);
  endfunction

endpackage

// File: rtl/vnic_src_bank.sv
module vnic_src_bank
  import vnic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_SRC-1:0]  mode_we,
  input  logic [NUM_SRC-1:0]  vec_we,
  input  logic [NUM_SRC-1:0]  en_bits,
  input  logic [NUM_SRC-1:0]  dis_bits,
  input  logic [NUM_SRC-1:0]  set_bits,
  input  logic [NUM_SRC-1:0]  clr_bits,
  input  logic [NUM_SRC-1:0]  ack_bits,
  output prio_t               prio_o [NUM_SRC],
  output trig_e               trig_o [NUM_SRC],
  output logic [DATA_W-1:0]   vec_o  [NUM_SRC],
  output logic [NUM_SRC-1:0]  mask_o,
  output logic [NUM_SRC-1:0]  pend_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    trig_e             trig_q;
    prio_t             prio_q;
    logic [DATA_W-1:0] vec_q;
    logic              latch_q;
    logic              in_q;
    logic              in_prev_q;
    logic              mask_q;
    logic              edge_hit;

    assign edge_hit = trig_is_edge(trig_q) && edge_seen(trig_q, in_q, in_prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trig_q    <= TRIG_HIGH;
        prio_q    <= '0;
        vec_q     <= '0;
        latch_q   <= 1'b0;
        in_q      <= 1'b0;
        in_prev_q <= 1'b0;
        mask_q    <= 1'b0;
      end else begin
        in_q      <= src_i[g];
        in_prev_q <= in_q;
        if (mode_we[g]) begin
          prio_q <= wdata[PRIO_W-1:0];
          trig_q <= trig_e'(wdata[MODE_TRIG_LSB +: 2]);
        end
        if (vec_we[g]) vec_q <= wdata;
        if (en_bits[g])       mask_q <= 1'b1;
        else if (dis_bits[g]) mask_q <= 1'b0;
        // a fresh request wins over a clear or acknowledge in the same cycle
        if (set_bits[g] || edge_hit)      latch_q <= 1'b1;
        else if (clr_bits[g] || ack_bits[g]) latch_q <= 1'b0;
      end
    end

    assign prio_o[g] = prio_q;
    assign trig_o[g] = trig_q;
    assign vec_o[g]  = vec_q;
    assign mask_o[g] = mask_q;
    assign pend_o[g] = latch_q | (!trig_is_edge(trig_q) && level_active(trig_q, in_q));
  end

endmodule

// File: rtl/vnic_arbiter.sv
module vnic_arbiter
  import vnic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req,
  input  prio_t              prio_i [NUM_SRC],
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output prio_t              win_prio
);

  // scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i] && (!win_valid || prio_i[i] >= win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = prio_i[i];
      end
    end
  end

endmodule

// File: rtl/vnic_nest_stack.sv
module vnic_nest_stack
  import vnic_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 5,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  prio_t            push_prio,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [CNT_W-1:0] depth,
  output logic             top_valid,
  output prio_t            top_prio,
  output logic [IDX_W-1:0] top_idx
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  prio_t            prio_mem [DEPTH];
  logic [IDX_W-1:0] idx_mem  [DEPTH];
  logic [CNT_W-1:0] depth_q;
  logic             full;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  assign full   = (depth_q == CNT_W'(DEPTH));
  assign wr_ptr = PTR_W'(depth_q);
  assign rd_ptr = PTR_W'(depth_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        prio_mem[i] <= '0;
        idx_mem[i]  <= '0;
      end
    end else if (push && !full) begin
      prio_mem[wr_ptr] <= push_prio;
      idx_mem[wr_ptr]  <= push_idx;
      depth_q          <= depth_q + CNT_W'(1);
    end else if (pop && depth_q != '0) begin
      depth_q <= depth_q - CNT_W'(1);
    end
  end

  assign depth     = depth_q;
  assign top_valid = (depth_q != '0);
  assign top_prio  = top_valid ? prio_mem[rd_ptr] : '0;
  assign top_idx   = top_valid ? idx_mem[rd_ptr]  : '0;

endmodule

// File: rtl/vnic_top.sv
module vnic_top
  import vnic_pkg::*;
#(
  parameter int NUM_SRC    = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 10,
  parameter int NEST_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_n
);

  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int CNT_W    = $clog2(NEST_DEPTH + 1);
  localparam int MODE_END = NUM_SRC * 4;
  localparam int VEC_END  = A_VEC_BASE + NUM_SRC * 4;

  // ---- bus decode ----
  logic             rd_req, wr_req;
  logic             mode_hit, vec_hit;
  logic [IDX_W-1:0] mode_idx, vec_idx;
  logic             hit_ack, hit_en, hit_dis, hit_clr, hit_set, hit_eoi, hit_spur, hit_dbg;

  assign rd_req   = bus_sel & ~bus_wr;
  assign wr_req   = bus_sel &  bus_wr;
  assign mode_hit = 32'(bus_addr) < MODE_END;
  assign vec_hit  = (32'(bus_addr) >= A_VEC_BASE) && (32'(bus_addr) < VEC_END);
  assign mode_idx = IDX_W'(32'(bus_addr) >> 2);
  assign vec_idx  = IDX_W'((32'(bus_addr) - A_VEC_BASE) >> 2);
  assign hit_ack  = bus_addr == ADDR_W'(A_ACK);
  assign hit_en   = bus_addr == ADDR_W'(A_EN);
  assign hit_dis  = bus_addr == ADDR_W'(A_DIS);
  assign hit_clr  = bus_addr == ADDR_W'(A_CLR);
  assign hit_set  = bus_addr == ADDR_W'(A_SET);
  assign hit_eoi  = bus_addr == ADDR_W'(A_EOI);
  assign hit_spur = bus_addr == ADDR_W'(A_SPUR);
  assign hit_dbg  = bus_addr == ADDR_W'(A_DBG);

  // ---- named events (also observed by the checker) ----
  logic               en_wr, dis_wr, eoi_evt, ack_evt, spur_evt, eligible;
  logic [NUM_SRC-1:0] mode_we, vec_we, en_bits, dis_bits, set_bits, clr_bits, ack_bits;
  logic [NUM_SRC-1:0] mask_w, pend_w, req_w;
  logic [CNT_W-1:0]   depth_w;

  assign en_wr    = wr_req & hit_en;
  assign dis_wr   = wr_req & hit_dis;
  assign eoi_evt  = wr_req & hit_eoi;
  assign mode_we  = (wr_req && mode_hit) ? (NUM_SRC'(1) << mode_idx) : '0;
  assign vec_we   = (wr_req && vec_hit)  ? (NUM_SRC'(1) << vec_idx)  : '0;
  assign en_bits  = en_wr ? bus_wdata[NUM_SRC-1:0] : '0;
  assign dis_bits = dis_wr ? bus_wdata[NUM_SRC-1:0] : '0;
  assign set_bits = (wr_req && hit_set) ? bus_wdata[NUM_SRC-1:0] : '0;
  assign clr_bits = (wr_req && hit_clr) ? bus_wdata[NUM_SRC-1:0] : '0;

  // ---- per-source state ----
  prio_t             prio_w [NUM_SRC];
  trig_e             trig_w [NUM_SRC];
  logic [DATA_W-1:0] vec_w  [NUM_SRC];

  vnic_src_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .wdata    (bus_wdata),
    .mode_we  (mode_we),
    .vec_we   (vec_we),
    .en_bits  (en_bits),
    .dis_bits (dis_bits),
    .set_bits (set_bits),
    .clr_bits (clr_bits),
    .ack_bits (ack_bits),
    .prio_o   (prio_w),
    .trig_o   (trig_w),
    .vec_o    (vec_w),
    .mask_o   (mask_w),
    .pend_o   (pend_w)
  );

  assign req_w = pend_w & mask_w;

  // ---- arbitration ----
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  prio_t            win_prio;

  vnic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .req       (req_w),
    .prio_i    (prio_w),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  // ---- nesting stack ----
  logic             top_valid;
  prio_t            top_prio;
  logic [IDX_W-1:0] top_idx;

  vnic_nest_stack #(.DEPTH(NEST_DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack_evt),
    .push_prio (win_prio),
    .push_idx  (win_idx),
    .pop       (eoi_evt),
    .depth     (depth_w),
    .top_valid (top_valid),
    .top_prio  (top_prio),
    .top_idx   (top_idx)
  );

  assign eligible = win_valid && outranks(win_prio, top_valid, top_prio);
  assign irq_n    = ~eligible;
  assign ack_evt  = rd_req & hit_ack & eligible;
  assign spur_evt = rd_req & hit_ack & ~eligible;
  assign ack_bits = ack_evt ? (NUM_SRC'(1) << win_idx) : '0;

  // ---- plain registers ----
  logic [DATA_W-1:0] spur_q;
  logic              dbg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spur_q <= '0;
      dbg_q  <= 1'b0;
    end else begin
      if (wr_req && hit_spur) spur_q <= bus_wdata;
      if (wr_req && hit_dbg)  dbg_q  <= bus_wdata[0];
    end
  end

  // ---- read path ----
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_next = '0;
    if (mode_hit) begin
      rd_next[PRIO_W-1:0]          = prio_w[mode_idx];
      rd_next[MODE_TRIG_LSB +: 2]  = trig_w[mode_idx];
    end else if (vec_hit) begin
      rd_next = vec_w[vec_idx];
    end else if (hit_ack) begin
      rd_next = eligible ? vec_w[win_idx] : spur_q;
    end else if (bus_addr == ADDR_W'(A_STATUS)) begin
      rd_next = DATA_W'(top_idx);
    end else if (bus_addr == ADDR_W'(A_PEND)) begin
      rd_next = DATA_W'(pend_w);
    end else if (bus_addr == ADDR_W'(A_MASK)) begin
      rd_next = DATA_W'(mask_w);
    end else if (hit_spur) begin
      rd_next = spur_q;
    end else if (hit_dbg) begin
      rd_next = DATA_W'(dbg_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/vnic_checker.sv
module vnic_checker #(
  parameter int NUM_SRC    = 32,
  parameter int NEST_DEPTH = 8,
  parameter int CNT_W      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_n,
  input logic               ack_evt,
  input logic               spur_evt,
  input logic               eoi_evt,
  input logic               en_wr,
  input logic               dis_wr,
  input logic [NUM_SRC-1:0] wdata_lo,
  input logic [NUM_SRC-1:0] mask,
  input logic [NUM_SRC-1:0] req,
  input logic [CNT_W-1:0]   depth
);

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(NEST_DEPTH)); // R10

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_evt && depth != '0) |=> depth == $past(depth) - CNT_W'(1)); // R10

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_evt && depth == '0) |=> depth == '0); // R10

  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && depth < CNT_W'(NEST_DEPTH)) |=> depth == $past(depth) + CNT_W'(1)); // R7

  AST_SPUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    spur_evt |=> $stable(depth)); // R8

  AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (mask & $past(wdata_lo)) == $past(wdata_lo)); // R3

  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> (mask & $past(wdata_lo)) == '0); // R3

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> irq_n); // R6

endmodule

bind vnic_top vnic_checker #(
  .NUM_SRC    (NUM_SRC),
  .NEST_DEPTH (NEST_DEPTH),
  .CNT_W      (CNT_W)
) u_vnic_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_n    (irq_n),
  .ack_evt  (ack_evt),
  .spur_evt (spur_evt),
  .eoi_evt  (eoi_evt),
  .en_wr    (en_wr),
  .dis_wr   (dis_wr),
  .wdata_lo (bus_wdata[NUM_SRC-1:0]),
  .mask     (mask_w),
  .req      (req_w),
  .depth    (depth_w)
);

// File: tb/vnic_top_tb_top.sv
`timescale 1ns/1ps
module vnic_top_tb_top;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         irq_n;

  always #2.5 clk = ~clk;

  vnic_top dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_n(irq_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // ---------------- behavioural reference ----------------
  int          m_prio [N];
  int          m_trig [N];   // 0 high, 1 rise, 2 low, 3 fall
  logic [31:0] m_vec  [N];
  bit          m_lat  [N];
  bit          m_msk  [N];
  bit          m_in   [N];
  bit          m_prev [N];
  logic [31:0] m_spur;
  bit          m_dbg;
  int          stk_p [$];
  int          stk_s [$];
  logic [31:0] exp_rd;

  function automatic bit m_pend(int i);
    bit lvl;
    lvl = (m_trig[i] == 0) ? m_in[i] : (m_trig[i] == 2) ? !m_in[i] : 1'b0;
    return m_lat[i] | lvl;
  endfunction

  function automatic int m_best();
    int b;
    int top;
    b = -1;
    top = (stk_p.size() == 0) ? -1 : stk_p[$];
    for (int i = 0; i < N; i++)
      if (m_pend(i) && m_msk[i] && m_prio[i] > top && (b < 0 || m_prio[i] > m_prio[b])) b = i;
    return b;
  endfunction

  function automatic logic [31:0] m_read(int a, int b);
    logic [31:0] r;
    r = '0;
    if (a < 4*N) begin
      r[2:0] = 3'(m_prio[a/4]);
      r[6:5] = 2'(m_trig[a/4]);
    end else if (a >= 'h80 && a < 'h80 + 4*N) r = m_vec[(a - 'h80)/4];
    else if (a == 'h100) r = (b >= 0) ? m_vec[b] : m_spur;
    else if (a == 'h108) r = (stk_s.size() == 0) ? 0 : 32'(stk_s[$]);
    else if (a == 'h10C) begin for (int i = 0; i < N; i++) r[i] = m_pend(i); end
    else if (a == 'h110) begin for (int i = 0; i < N; i++) r[i] = m_msk[i]; end
    else if (a == 'h134) r = m_spur;
    else if (a == 'h138) r = {31'd0, m_dbg};
    return r;
  endfunction

  always @(posedge clk) begin : model
    int b;
    int a;
    bit drop [N];
    bit raise [N];
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_prio[i] = 0; m_trig[i] = 0; m_vec[i] = '0; m_lat[i] = 0;
        m_msk[i] = 0; m_in[i] = 0; m_prev[i] = 0;
      end
      m_spur = '0; m_dbg = 0; stk_p.delete(); stk_s.delete(); exp_rd = '0;
    end else begin
      b = m_best();
      a = int'(addr);
      for (int i = 0; i < N; i++) begin
        drop[i]  = 0;
        raise[i] = (m_trig[i] == 1 && !m_prev[i] && m_in[i]) ||
                   (m_trig[i] == 3 && m_prev[i] && !m_in[i]);
      end
      if (sel && !wr) begin
        exp_rd = m_read(a, b);
        if (a == 'h100 && b >= 0) begin
          drop[b] = 1;
          if (stk_p.size() < 8) begin stk_p.push_back(m_prio[b]); stk_s.push_back(b); end
        end
      end
      if (sel && wr) begin
        if (a < 4*N) begin
          m_prio[a/4] = int'(wdata[2:0]);
          m_trig[a/4] = int'(wdata[6:5]);
        end else if (a >= 'h80 && a < 'h80 + 4*N) m_vec[(a - 'h80)/4] = wdata;
        else if (a == 'h120) begin for (int i = 0; i < N; i++) if (wdata[i]) m_msk[i] = 1; end
        else if (a == 'h124) begin for (int i = 0; i < N; i++) if (wdata[i]) m_msk[i] = 0; end
        else if (a == 'h128) begin for (int i = 0; i < N; i++) if (wdata[i]) drop[i] = 1; end
        else if (a == 'h12C) begin for (int i = 0; i < N; i++) if (wdata[i]) raise[i] = 1; end
        else if (a == 'h130) begin
          if (stk_p.size() > 0) begin void'(stk_p.pop_back()); void'(stk_s.pop_back()); end
        end
        else if (a == 'h134) m_spur = wdata;
        else if (a == 'h138) m_dbg = wdata[0];
      end
      for (int i = 0; i < N; i++) begin
        if (raise[i]) m_lat[i] = 1;
        else if (drop[i]) m_lat[i] = 0;
        m_prev[i] = m_in[i];
        m_in[i]   = src[i];
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // R6: interrupt line compared with the model on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) check({31'd0, irq_n}, {31'd0, m_best() < 0}, "R6 irq_n vs model");
  end

  task automatic bus_op(bit w, int a, logic [31:0] d);
    sel = 1'b1; wr = w; addr = 10'(a); wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    bus_op(1'b1, a, d);
  endtask

  task automatic rd_chk(int a, string tag);
    bus_op(1'b0, a, '0);
    check(rdata, exp_rd, tag);
  endtask

  task automatic rd_lit(int a, logic [31:0] lit, string tag);
    bus_op(1'b0, a, '0);
    check(rdata, exp_rd, tag);
    check(rdata, lit, tag);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check({31'd0, irq_n}, 32'd1, "R1 irq_n after reset");
    rd_lit('h110, 32'h0, "R1 mask after reset");
    rd_lit('h10C, 32'h0, "R1 pending after reset");
    rd_lit('h108, 32'h0, "R9 status empty after reset");
    rd_lit('h0C, 32'h0, "R1 mode after reset");

    // R2 mode, vector and spurious registers
    wr_reg('h0C, 32'h0000_0005);
    rd_lit('h0C, 32'h0000_0005, "R2 mode readback");
    wr_reg('h10, 32'hFFFF_FFFF);
    rd_lit('h10, 32'h0000_0067, "R2 mode reserved bits");
    wr_reg('h10, 32'h0);
    for (int i = 0; i < N; i++) wr_reg('h80 + 4*i, 32'h1000 + i);
    rd_lit('h80 + 4*17, 32'h1011, "R2 vector readback");
    wr_reg('h134, 32'hDEAD_BEEF);
    rd_lit('h134, 32'hDEAD_BEEF, "R2 spurious readback");

    // R11 debug control and write-only words
    wr_reg('h138, 32'hFFFF_FFFF);
    rd_lit('h138, 32'h1, "R11 debug bit readback");
    wr_reg('h138, 32'h0);
    rd_lit('h138, 32'h0, "R11 debug cleared");
    rd_lit('h120, 32'h0, "R11 command word reads zero");

    // R3 mask commands
    wr_reg('h120, 32'h0000_0018);
    rd_lit('h110, 32'h0000_0018, "R3 enable sets");
    wr_reg('h120, 32'h0);
    rd_lit('h110, 32'h0000_0018, "R3 zero enable ignored");
    wr_reg('h124, 32'h0000_0008);
    rd_lit('h110, 32'h0000_0010, "R3 disable clears one");
    wr_reg('h124, 32'hFFFF_FFFF);
    rd_lit('h110, 32'h0, "R3 disable all");

    // R4 level and edge triggers
    wr_reg('h14, 32'h0000_0002);            // src5 high level prio 2
    wr_reg('h120, 32'h0000_0060);
    src[5] = 1'b1; idle(1);
    rd_lit('h10C, 32'h0000_0020, "R4 high level pending");
    src[5] = 1'b0; idle(2);
    rd_chk('h10C, "R4 level drops");
    wr_reg('h18, 32'h0000_0021);            // src6 rising prio 1
    src[6] = 1'b1; idle(1); src[6] = 1'b0; idle(3);
    rd_lit('h10C, 32'h0000_0040, "R4 rising latched");
    wr_reg('h38, 32'h0000_0042);            // src14 low level
    rd_chk('h10C, "R4 low level pending");
    src[14] = 1'b1; idle(2);
    rd_chk('h10C, "R4 low level released");
    wr_reg('h3C, 32'h0000_0061);            // src15 falling
    src[15] = 1'b1; idle(2); src[15] = 1'b0; idle(3);
    rd_chk('h10C, "R4 falling latched");

    // R5 set and clear commands
    wr_reg('h128, 32'h0000_8040);
    rd_lit('h10C, 32'h0, "R5 clear latches");
    wr_reg('h12C, 32'h0000_0080);
    rd_lit('h10C, 32'h0000_0080, "R5 set latch");
    wr_reg('h128, 32'h0);
    rd_chk('h10C, "R5 zero clear ignored");
    wr_reg('h128, 32'h0000_0080);
    rd_chk('h10C, "R5 clear after set");

    // R7 R8 R9 R10 nesting
    wr_reg('h28, 32'h1); wr_reg('h2C, 32'h3); wr_reg('h30, 32'h3); wr_reg('h34, 32'h6);
    wr_reg('h120, 32'h0000_3C00);
    rd_lit('h100, 32'hDEAD_BEEF, "R8 spurious when idle");
    wr_reg('h12C, 32'h0000_0400);
    rd_lit('h100, 32'h0000_100A, "R7 ack vector");
    rd_lit('h108, 32'd10, "R9 status after ack");
    rd_chk('h10C, "R7 ack clears latch");
    wr_reg('h12C, 32'h0000_1800);
    rd_lit('h100, 32'h0000_100B, "R7 tie to lower index");
    rd_lit('h100, 32'hDEAD_BEEF, "R8 equal priority no preempt");
    rd_lit('h108, 32'd11, "R9 status unchanged");
    wr_reg('h130, 32'h0);
    rd_lit('h100, 32'h0000_100C, "R7 ack after pop");
    wr_reg('h130, 32'h0); wr_reg('h130, 32'h0);
    rd_lit('h108, 32'd0, "R9 status after unwind");
    wr_reg('h130, 32'h0);
    rd_chk('h108, "R10 pop on empty");
    rd_lit('h100, 32'hDEAD_BEEF, "R10 empty stack spurious");

    // R7 on an edge source
    wr_reg('h18, 32'h0000_0024);             // src6 rising prio 4
    src[6] = 1'b1; idle(1); src[6] = 1'b0; idle(2);
    rd_lit('h100, 32'h0000_1006, "R7 edge ack vector");
    rd_chk('h10C, "R7 edge latch cleared");
    wr_reg('h130, 32'h0);

    // R10 full eight levels
    for (int k = 0; k < 8; k++) wr_reg(4*(20+k), 32'(k));
    wr_reg('h120, 32'h0FF0_0000);
    for (int k = 0; k < 8; k++) begin
      wr_reg('h12C, 32'h1 << (20+k));
      rd_chk('h100, "R7 fill stack");
    end
    wr_reg('h12C, 32'h0000_2000);            // src13 prio 6 pending
    rd_lit('h100, 32'hDEAD_BEEF, "R10 full stack blocks");
    rd_lit('h108, 32'd27, "R9 status at full depth");
    for (int k = 0; k < 8; k++) begin
      wr_reg('h130, 32'h0);
      rd_chk('h108, "R10 unwind step");
    end
    rd_lit('h108, 32'd0, "R10 eight pops empty");
    rd_lit('h100, 32'h0000_100D, "R7 ack after unwind");
    wr_reg('h130, 32'h0);
    wr_reg('h130, 32'h0);
    rd_lit('h108, 32'd0, "R10 extra pop harmless");
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule